// File: doc/BRIEF.md
# Nested Prioritizing Interrupt Controller

This block gathers twenty-nine interrupt request lines. Seventeen come from on-chip peripherals and twelve from external port pins. A rising edge on a line latches a pending bit. Pending bits are gated by a per-source enable mask, ranked, and reported as a single request on one of eight level lines toward the system interface. Software chooses which level line is used.

Ranking follows a fixed order by source index. Two changes to that order are available. First, a group of five serial-controller sources (indices 8 to 12) can either stay in one contiguous block or be spread evenly through the order. Second, any single source can be promoted above every other source.

On an acknowledge strobe the block returns the winning source's vector and records that source in an in-service register. While a source is in service, only sources ranked strictly above it can raise the output, so handlers nest fully. Software ends a service period by writing a 1 to the source's in-service bit. All registers sit behind a small synchronous write port with a combinational read port.

Top module: `irq_nest_ctl`

## Requirements
- R1: A rising edge on `src_i[k]` sets pending bit k (register address 1) at the next clock edge. If the same cycle also carries a clear for that bit, the set wins.
- R2: A write to address 1 clears every pending bit whose write-data bit is 1. Write-data bits of 0 leave pending bits unchanged.
- R3: The mask register (address 2) uses 1 to enable a source. A pending source whose mask bit is 0 never raises the output. The mask resets to all zeros.
- R4: The configuration register is at address 0 with these fields: bit 0 is the global enable, bits 3:1 are the level, bits 8:4 are the promoted source and bit 9 is the scheme. `irq_lvl_o` is registered. It is either all zero or one-hot, with the set bit at the configured level. It is set one edge after an eligible pending bit exists, provided the enable is 1. When the enable is 0 it stays zero.
- R5: With scheme 0 (configuration bit 9 = 0), a lower source index has higher priority.
- R6: With scheme 1, serial-group source 8+k (k = 0..4) takes priority slot 6k+2. The other sources fill the remaining slots in index order. For example, source 8 beats source 2, and source 13 beats source 12.
- R7: The source named in configuration bits 8:4 outranks all other sources. A value of 29 to 31 promotes no source.
- R8: An acknowledge with an eligible source returns, one edge later, vector = winner index + 1 on `vec_o`. At the same edge it sets the winner's in-service bit. `vec_o` holds its value until the next acknowledge.
- R9: An acknowledge with no eligible source returns vector 0 and leaves the in-service register unchanged.
- R10: A source is eligible only when it is pending, enabled by the mask, and ranked strictly above every in-service source. An equal or lower source is held back.
- R11: A write to address 3 clears the in-service bits whose write-data bit is 1. Write-data bits of 0 have no effect.
- R12: After reset all registers read 0, `irq_lvl_o` is 0 and `vec_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 29 | Interrupt request lines, rising-edge sensitive |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| vec_o | output | 5 | Vector from the last acknowledge |
| irq_lvl_o | output | 8 | One-hot interrupt request toward the system interface |

## Verification
The bench toggles the scheme on pairs of sources whose relative order reverses under scheme 1. A priority map with the wrong slot arithmetic picks the wrong vector for one of these pairs. It also promotes low-ranked sources, so an override that is ignored or applied to the wrong index shows up as a wrong vector. Nesting is exercised with an equal-rank source and a lower-rank source against one in service, then with a higher-rank source. A ceiling compare that is off by one, or that uses the wrong sign, raises or suppresses the output at the wrong time. Acknowledges with nothing eligible, write-0 no-op clears and masked-but-pending sources catch designs that set stray in-service bits, clear too broadly, or leak masked requests.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    localparam int NUM_SRC    = 29;
    localparam int SRC_W      = 5;
    localparam int LVL_W      = 3;
    localparam int KEY_W      = SRC_W + 1;
    localparam int GRP_BASE   = 8;
    localparam int GRP_N      = 5;
    localparam int GRP_STRIDE = 6;
    localparam int GRP_OFS    = 2;
    localparam int ADDR_W     = 2;
    localparam int DATA_W     = 32;

    localparam logic [ADDR_W-1:0] A_CFG  = 2'd0;
    localparam logic [ADDR_W-1:0] A_PEND = 2'd1;
    localparam logic [ADDR_W-1:0] A_MASK = 2'd2;
    localparam logic [ADDR_W-1:0] A_INSV = 2'd3;

    typedef struct packed {
        logic             sch;
        logic [SRC_W-1:0] hp;
        logic [LVL_W-1:0] lvl;
        logic             en;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    // Priority slot of source s; slot 0 is the highest.
    function automatic int rank_of(input int s, input bit sch, input int n,
                                   input int base, input int gn,
                                   input int stride, input int ofs);
        int ord;
        int cnt;
        int res;
        res = s;
        if (sch) begin
            if (s >= base && s < base + gn) begin
                res = stride * (s - base) + ofs;
            end else begin
                ord = (s < base) ? s : s - gn;
                cnt = 0;
                for (int slot = 0; slot < n; slot++) begin
                    if (!((slot % stride) == ofs && (slot / stride) < gn)) begin
                        if (cnt == ord) res = slot;
                        cnt++;
                    end
                end
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/irq_rank_map.sv
module irq_rank_map #(
    parameter int NUM_SRC = irq_nest_pkg::NUM_SRC,
    parameter int SRC_W   = irq_nest_pkg::SRC_W,
    localparam int KEY_W  = SRC_W + 1
) (
    input  logic [SRC_W-1:0]              hp_i,
    input  logic                          sch_i,
    output logic [NUM_SRC-1:0][KEY_W-1:0] key_o
);
    import irq_nest_pkg::*;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_key
        localparam int RK0 = rank_of(s, 1'b0, NUM_SRC, GRP_BASE, GRP_N, GRP_STRIDE, GRP_OFS);
        localparam int RK1 = rank_of(s, 1'b1, NUM_SRC, GRP_BASE, GRP_N, GRP_STRIDE, GRP_OFS);
        logic promoted;
        assign promoted = (hp_i == SRC_W'(s));
        // Smaller key wins; the promoted source drops its top bit.
        assign key_o[s] = {!promoted, sch_i ? SRC_W'(RK1) : SRC_W'(RK0)};
    end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NUM_SRC = irq_nest_pkg::NUM_SRC,
    parameter int SRC_W   = irq_nest_pkg::SRC_W,
    localparam int KEY_W  = SRC_W + 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC-1:0]            pend_i,
    input  logic [NUM_SRC-1:0]            mask_i,
    input  logic [NUM_SRC-1:0]            insv_i,
    input  logic [NUM_SRC-1:0][KEY_W-1:0] key_i,
    output logic                          win_valid_o,
    output logic [SRC_W-1:0]              win_idx_o
);
    logic [KEY_W:0]       ceil_key;
    logic [KEY_W:0]       best_key;
    logic [NUM_SRC-1:0]   elig;

    always_comb begin
        ceil_key = {1'b1, {KEY_W{1'b0}}};
        for (int i = 0; i < NUM_SRC; i++) begin
            if (insv_i[i] && ({1'b0, key_i[i]} < ceil_key)) ceil_key = {1'b0, key_i[i]};
        end
        best_key  = '1;
        win_idx_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            elig[i] = pend_i[i] && mask_i[i] && ({1'b0, key_i[i]} < ceil_key);
            if (elig[i] && ({1'b0, key_i[i]} < best_key)) begin
                best_key  = {1'b0, key_i[i]};
                win_idx_o = SRC_W'(i);
            end
        end
        win_valid_o = |elig;
    end

    AST_WIN_IS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_o |-> (pend_i[win_idx_o] && mask_i[win_idx_o])); // R3
    AST_WIN_NOT_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_o |-> !insv_i[win_idx_o]); // R10

endmodule

// File: rtl/irq_nest_ctl.sv
module irq_nest_ctl #(
    parameter int NUM_SRC = irq_nest_pkg::NUM_SRC,
    parameter int SRC_W   = irq_nest_pkg::SRC_W,
    parameter int LVL_W   = irq_nest_pkg::LVL_W,
    parameter int ADDR_W  = irq_nest_pkg::ADDR_W,
    parameter int DATA_W  = irq_nest_pkg::DATA_W,
    localparam int KEY_W  = SRC_W + 1,
    localparam int LVL_N  = 1 << LVL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic               ack_i,
    output logic [SRC_W-1:0]   vec_o,
    output logic [LVL_N-1:0]   irq_lvl_o
);
    import irq_nest_pkg::*;

    typedef struct packed {
        cfg_t               cfg;
        logic [NUM_SRC-1:0] mask;
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] insv;
        logic [NUM_SRC-1:0] src_prev;
        logic [LVL_N-1:0]   irq;
        logic [SRC_W-1:0]   vec;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SRC-1:0][KEY_W-1:0] key;
    logic                          win_valid;
    logic [SRC_W-1:0]              win_idx;
    logic [NUM_SRC-1:0]            edges;
    logic [NUM_SRC-1:0]            pend_clr;
    logic [NUM_SRC-1:0]            insv_clr;
    logic [NUM_SRC-1:0]            insv_set;

    irq_rank_map #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) rank_i (
        .hp_i  (st_q.cfg.hp),
        .sch_i (st_q.cfg.sch),
        .key_o (key)
    );

    irq_pick #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) pick_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_i      (st_q.pend),
        .mask_i      (st_q.mask),
        .insv_i      (st_q.insv),
        .key_i       (key),
        .win_valid_o (win_valid),
        .win_idx_o   (win_idx)
    );

    always_comb begin
        st_d     = st_q;
        edges    = src_i & ~st_q.src_prev;
        pend_clr = (wr_en && addr == A_PEND) ? wdata[NUM_SRC-1:0] : '0;
        insv_clr = (wr_en && addr == A_INSV) ? wdata[NUM_SRC-1:0] : '0;
        insv_set = '0;

        st_d.src_prev = src_i;
        st_d.pend     = (st_q.pend & ~pend_clr) | edges;

        if (wr_en && addr == A_CFG)  st_d.cfg  = cfg_t'(wdata[CFG_W-1:0]);
        if (wr_en && addr == A_MASK) st_d.mask = wdata[NUM_SRC-1:0];

        if (ack_i) begin
            if (win_valid) begin
                insv_set[win_idx] = 1'b1;
                st_d.vec          = win_idx + SRC_W'(1);
            end else begin
                st_d.vec = '0;
            end
        end
        st_d.insv = (st_q.insv & ~insv_clr) | insv_set;

        st_d.irq = '0;
        if (st_q.cfg.en && win_valid) st_d.irq[st_q.cfg.lvl] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (addr)
            A_CFG:   rdata = DATA_W'(st_q.cfg);
            A_PEND:  rdata = DATA_W'(st_q.pend);
            A_MASK:  rdata = DATA_W'(st_q.mask);
            default: rdata = DATA_W'(st_q.insv);
        endcase
    end

    assign vec_o     = st_q.vec;
    assign irq_lvl_o = st_q.irq;

    AST_EDGE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src_i & ~st_q.src_prev)) |=>
        ((st_q.pend & $past(src_i & ~st_q.src_prev)) == $past(src_i & ~st_q.src_prev))); // R1
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_lvl_o) |-> $past(|(st_q.pend & st_q.mask))); // R3
    AST_LVL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_lvl_o)); // R4
    AST_LVL_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_lvl_o) |-> (irq_lvl_o[$past(st_q.cfg.lvl)] && $past(st_q.cfg.en))); // R4
    AST_ACK_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && win_valid) |=> ((vec_o != '0) && (|st_q.insv))); // R8
    AST_ACK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !win_valid && !(wr_en && addr == A_INSV)) |=>
        ((vec_o == '0) && $stable(st_q.insv))); // R9

endmodule

// File: tb/irq_nest_ctl_tb.sv
module irq_nest_ctl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [28:0] src = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ack = 1'b0;
    logic [4:0]  vec;
    logic [7:0]  irq;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    irq_nest_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ack_i(ack), .vec_o(vec), .irq_lvl_o(irq)
    );

    // Table entry: {sources pulsed [39:11], promoted [10:6], scheme [5], expected vector [4:0]}
    localparam int NV = 8;
    localparam logic [39:0] VECS [NV] = '{
        {(29'd1 << 3)  | (29'd1 << 10), 5'd31, 1'b0, 5'd4 },  // R5
        {(29'd1 << 2)  | (29'd1 << 8),  5'd31, 1'b0, 5'd3 },  // R5
        {(29'd1 << 2)  | (29'd1 << 8),  5'd31, 1'b1, 5'd9 },  // R6
        {(29'd1 << 12) | (29'd1 << 13), 5'd31, 1'b0, 5'd13},  // R5
        {(29'd1 << 12) | (29'd1 << 13), 5'd31, 1'b1, 5'd14},  // R6
        {(29'd1 << 0)  | (29'd1 << 28), 5'd28, 1'b0, 5'd29},  // R7
        {(29'd1 << 5)  | (29'd1 << 20), 5'd20, 1'b1, 5'd21},  // R7
        {29'd0,                         5'd31, 1'b0, 5'd0 }   // R9
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse(input logic [28:0] m);
        src = m;
        tick();
        src = '0;
    endtask

    task automatic acknowledge();
        ack = 1'b1;
        tick();
        ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R12 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), r);
            chk("R12 register", r, 32'd0);
        end
        chk("R12 irq", 32'(irq), 32'd0);
        chk("R12 vec", 32'(vec), 32'd0);

        // R3: pending but masked source stays silent
        wr(2'd0, 32'h0000_000B);            // enable, level 5
        pulse(29'd1 << 5);
        repeat (3) tick();
        chk("R3 masked irq", 32'(irq), 32'd0);
        rd(2'd1, r);
        chk("R1 pending set", r, 32'd1 << 5);
        wr(2'd2, 32'd1 << 5);
        tick();
        chk("R4 level 5", 32'(irq), 32'h20);
        wr(2'd0, 32'h0000_000A);            // enable off
        tick();
        chk("R4 enable off", 32'(irq), 32'd0);

        // R2: write-one-to-clear
        wr(2'd1, 32'd0);
        rd(2'd1, r);
        chk("R2 write zero", r, 32'd1 << 5);
        wr(2'd1, 32'd1 << 5);
        rd(2'd1, r);
        chk("R2 write one", r, 32'd0);

        // R1/R4 latency
        wr(2'd0, 32'h0000_000B);
        wr(2'd2, 32'h1FFF_FFFF);
        tick();
        pulse(29'd1 << 7);
        rd(2'd1, r);
        chk("R1 pend after one edge", r, 32'd1 << 7);
        chk("R4 irq not yet", 32'(irq), 32'd0);
        tick();
        chk("R4 irq after second edge", 32'(irq), 32'h20);

        // Priority table: R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            wr(2'd3, 32'h1FFF_FFFF);
            wr(2'd1, 32'h1FFF_FFFF);
            wr(2'd0, {22'd0, VECS[i][5], VECS[i][10:6], 3'd0, 1'b1});
            if (VECS[i][39:11] != 29'd0) pulse(VECS[i][39:11]);
            tick();
            rd(2'd1, r);
            chk("R1 table pending", r, 32'(VECS[i][39:11]));
            acknowledge();
            chk("R5 R6 R7 R8 R9 table vector", 32'(vec), 32'(VECS[i][4:0]));
        end

        // Nesting: R8 R9 R10 R11
        wr(2'd3, 32'h1FFF_FFFF);
        wr(2'd1, 32'h1FFF_FFFF);
        wr(2'd0, 32'h0000_01F5);            // enable, level 2, no promotion, scheme 0
        pulse(29'd1 << 10);
        tick();
        chk("R4 level 2", 32'(irq), 32'h04);
        acknowledge();
        chk("R8 vector 11", 32'(vec), 32'd11);
        rd(2'd3, r);
        chk("R8 in-service", r, 32'd1 << 10);
        repeat (2) tick();
        chk("R10 equal held", 32'(irq), 32'd0);
        pulse(29'd1 << 12);
        repeat (2) tick();
        chk("R10 lower held", 32'(irq), 32'd0);
        pulse(29'd1 << 3);
        tick();
        chk("R10 higher nests", 32'(irq), 32'h04);
        acknowledge();
        chk("R8 nested vector", 32'(vec), 32'd4);
        rd(2'd3, r);
        chk("R8 two in service", r, (32'd1 << 3) | (32'd1 << 10));
        acknowledge();
        chk("R9 empty vector", 32'(vec), 32'd0);
        rd(2'd3, r);
        chk("R9 in-service kept", r, (32'd1 << 3) | (32'd1 << 10));
        wr(2'd3, 32'd0);
        rd(2'd3, r);
        chk("R11 write zero", r, (32'd1 << 3) | (32'd1 << 10));
        wr(2'd3, 32'd1 << 3);
        rd(2'd3, r);
        chk("R11 write one", r, 32'd1 << 10);
        tick();
        chk("R10 R11 reopened", 32'(irq), 32'h04);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule